// File: doc/BRIEF.md
# Linked-Descriptor Receive DMA Channel

This block is a single receive DMA channel. It follows a chain of buffer descriptors kept in a small local descriptor memory. It copies bytes arriving on a byte-stream input, where a last flag closes each frame, into the buffer that the current descriptor names. When a frame ends, it returns the descriptor to software by clearing the descriptor's ownership bit. Both the descriptor memory and the buffer memory are modelled inside the block. Software fills the descriptor memory through a write port and reads it back through a separate read port. Buffer contents are read back through a byte read port.

Software arms descriptors by setting their ownership bit and then starts the channel by writing a head pointer. The channel then walks the chain. At the end of the chain it marks the last descriptor as end-of-queue and stops; a fresh head write restarts it. Finished work is acknowledged through a completion-pointer register, which also clears a raw interrupt flag. A teardown request stops the channel at any point and leaves a fixed marker in the completion pointer. A frame that arrives while the current descriptor still belongs to software is swallowed and counted as an overrun.

Top module: `rxdma_chan`

## Requirements
- R1: After reset the channel is inactive, `in_ready`, `irq_raw` and `overrun_cnt` are 0, and `cpl_rd_data` reads 0.
- R2: A head write with a nonzero byte address while the channel is idle starts it at that descriptor. A head write of zero leaves the channel idle. A head write while the channel is active is ignored.
- R3: A descriptor sits at a 16-byte-aligned byte address in descriptor memory and holds four words: word 0 is the next pointer, word 1 is the buffer byte address, word 2 carries the buffer length in bits 15:0, and word 3 is the flags word. Bit 29 of the flags word is ownership, and 1 means the descriptor is owned by hardware.
- R4: Byte i of a frame is stored at buffer address (buffer pointer + i) when i is less than the buffer length. Bytes past the buffer length are consumed but not stored.
- R5: On frame end, the block rewrites the flags word with ownership (bit 29) cleared, start-of-packet (bit 31) and end-of-packet (bit 30) set, and the full frame length in bits 15:0.
- R6: If the finished descriptor's next pointer is zero, the block sets end-of-queue (bit 28) in its flags and the channel stops. Only a new head write restarts it.
- R7: If the frame length exceeds `max_len`, the block sets the error bit (bit 26) in the flags word.
- R8: While the current descriptor is not owned by hardware, an arriving frame is consumed and dropped, and `overrun_cnt` rises by exactly one per frame. The channel keeps re-reading the flags and resumes as soon as ownership is set.
- R9: `irq_raw` is set the cycle after each descriptor completes. It clears only when the completion pointer is written with the address of the most recently completed descriptor.
- R10: A completion-pointer write is readable on `cpl_rd_data`. A teardown request stops the channel and makes `cpl_rd_data` read 0xFFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsc_wr_en | input | 1 | Descriptor memory write strobe |
| dsc_wr_addr | input | 6 | Descriptor memory word address |
| dsc_wr_data | input | 32 | Descriptor memory write word |
| dsc_rd_addr | input | 6 | Descriptor memory read word address |
| dsc_rd_data | output | 32 | Descriptor memory read word |
| buf_rd_addr | input | 8 | Buffer memory read byte address |
| buf_rd_data | output | 8 | Buffer memory read byte |
| head_wr_en | input | 1 | Head pointer write strobe |
| head_wr_data | input | 32 | Head descriptor byte address |
| cpl_wr_en | input | 1 | Completion pointer write strobe |
| cpl_wr_data | input | 32 | Completion pointer write value |
| cpl_rd_data | output | 32 | Completion pointer value |
| teardown_req | input | 1 | Teardown request pulse |
| max_len | input | 16 | Largest frame accepted without error |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Last byte of frame |
| in_ready | output | 1 | Stream byte accepted |
| chan_active | output | 1 | Channel running |
| irq_raw | output | 1 | Raw completion interrupt |
| overrun_cnt | output | 8 | Dropped frame count |

## Verification
Embedded assertions check every cycle that an end-of-queue write stops the channel, that every descriptor write-back raises the interrupt, that teardown leaves the marker and an idle channel, that a zero head write never starts the channel, and that the overrun count only ever steps by one. The bench scenarios cover what needs whole frames and memory contents: the stored bytes and buffer truncation, the exact flags and length written back, the error bit on long frames, drop-then-resume when ownership arrives late, a head write ignored while active, and restart after end-of-queue.

// File: rtl/rxd_pkg.sv
`timescale 1ns/1ps
package rxd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_RECV = 3'd2,
    ST_DROP = 3'd3,
    ST_DONE = 3'd4
  } rxd_state_e;

  localparam int FLG_SOP = 31;
  localparam int FLG_EOP = 30;
  localparam int FLG_OWN = 29;
  localparam int FLG_EOQ = 28;
  localparam int FLG_ERR = 26;
  localparam logic [31:0] TEARDOWN_MARK = 32'hFFFF_FFFC;
endpackage

// File: rtl/rxd_desc_ram.sv
`timescale 1ns/1ps
module rxd_desc_ram #(
  parameter int DESC_WORDS = 64,
  localparam int DAW = $clog2(DESC_WORDS)
) (
  input  logic                  clk,
  input  logic                  sw_we,
  input  logic [DAW-1:0]        sw_waddr,
  input  logic [31:0]           sw_wdata,
  input  logic [DAW-1:0]        sw_raddr,
  output logic [31:0]           sw_rdata,
  input  logic [DAW-3:0]        hw_idx,
  output logic [3:0][31:0]      hw_words,
  input  logic                  hw_we,
  input  logic [1:0]            hw_sel,
  input  logic [31:0]           hw_wdata
);
  logic [31:0] mem [DESC_WORDS];

  // hardware write-back takes precedence over a software write in the same cycle
  always_ff @(posedge clk) begin
    if (hw_we) begin
      mem[{hw_idx, hw_sel}] <= hw_wdata;
    end else if (sw_we) begin
      mem[sw_waddr] <= sw_wdata;
    end
  end

  assign sw_rdata = mem[sw_raddr];

  for (genvar g = 0; g < 4; g++) begin : g_word
    assign hw_words[g] = mem[{hw_idx, 2'(g)}];
  end
endmodule

// File: rtl/rxd_buf_ram.sv
`timescale 1ns/1ps
module rxd_buf_ram #(
  parameter int BUF_BYTES = 256,
  localparam int BAW = $clog2(BUF_BYTES)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [BAW-1:0] waddr,
  input  logic [7:0]     wdata,
  input  logic [BAW-1:0] raddr,
  output logic [7:0]     rdata
);
  logic [7:0] mem [BUF_BYTES];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxd_ctrl.sv
`timescale 1ns/1ps
module rxd_ctrl
  import rxd_pkg::*;
#(
  parameter int DAW = 6,
  parameter int BAW = 8,
  parameter int OVW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  head_we,
  input  logic [31:0]           head_wdata,
  input  logic                  cp_we,
  input  logic [31:0]           cp_wdata,
  output logic [31:0]           cp_rdata,
  input  logic                  teardown,
  input  logic [15:0]           max_len,
  input  logic                  s_valid,
  input  logic [7:0]            s_data,
  input  logic                  s_last,
  output logic                  s_ready,
  output logic [DAW-3:0]        desc_idx,
  input  logic [3:0][31:0]      desc_words,
  output logic                  dhw_we,
  output logic [1:0]            dhw_sel,
  output logic [31:0]           dhw_wdata,
  output logic                  bw_we,
  output logic [BAW-1:0]        bw_addr,
  output logic [7:0]            bw_data,
  output logic                  active,
  output logic                  irq_raw,
  output logic [OVW-1:0]        overrun_cnt
);
  rxd_state_e  state_q, state_d;
  logic [31:0] cur_q, cur_d, nxt_q, nxt_d, bufp_q, bufp_d;
  logic [31:0] cp_q, cp_d, last_q, last_d;
  logic [15:0] blen_q, blen_d, cnt_q, cnt_d;
  logic        irq_q, irq_d;
  logic [OVW-1:0] ovr_q, ovr_d;
  logic        owned;
  logic [31:0] done_flags;
  logic        unused_bits;

  assign desc_idx = cur_q[DAW+1:4];
  assign owned    = desc_words[3][FLG_OWN];
  assign bw_addr  = bufp_q[BAW-1:0] + cnt_q[BAW-1:0];
  assign bw_data  = s_data;
  assign dhw_sel  = 2'd3;
  assign unused_bits = ^{cur_q[31:DAW+2], cur_q[3:0], bufp_q[31:BAW],
                         desc_words[2][31:16], desc_words[3]};

  always_comb begin
    done_flags          = '0;
    done_flags[15:0]    = cnt_q;
    done_flags[FLG_SOP] = 1'b1;
    done_flags[FLG_EOP] = 1'b1;
    done_flags[FLG_EOQ] = (nxt_q == '0);
    done_flags[FLG_ERR] = (cnt_q > max_len);
  end

  // next-state process
  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    nxt_d     = nxt_q;
    bufp_d    = bufp_q;
    blen_d    = blen_q;
    cnt_d     = cnt_q;
    cp_d      = cp_q;
    last_d    = last_q;
    irq_d     = irq_q;
    ovr_d     = ovr_q;
    dhw_we    = 1'b0;
    dhw_wdata = done_flags;
    bw_we     = 1'b0;

    if (cp_we) begin
      cp_d = cp_wdata;
      if (cp_wdata == last_q) irq_d = 1'b0;
    end

    unique case (state_q)
      ST_IDLE: begin
        if (head_we && head_wdata != '0) begin
          cur_d   = head_wdata;
          state_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (owned) begin
          nxt_d   = desc_words[0];
          bufp_d  = desc_words[1];
          blen_d  = desc_words[2][15:0];
          cnt_d   = '0;
          state_d = ST_RECV;
        end else if (s_valid) begin
          state_d = ST_DROP;
        end
      end
      ST_RECV: begin
        if (s_valid) begin
          bw_we = (cnt_q < blen_q);
          if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
          if (s_last) state_d = ST_DONE;
        end
      end
      ST_DROP: begin
        if (s_valid && s_last) begin
          ovr_d   = ovr_q + 1'b1;
          state_d = ST_LOAD;
        end
      end
      ST_DONE: begin
        dhw_we = 1'b1;
        irq_d  = 1'b1;
        last_d = cur_q;
        if (nxt_q == '0) begin
          state_d = ST_IDLE;
        end else begin
          cur_d   = nxt_q;
          state_d = ST_LOAD;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (teardown) begin
      state_d = ST_IDLE;
      cp_d    = TEARDOWN_MARK;
      dhw_we  = 1'b0;
      bw_we   = 1'b0;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      nxt_q   <= '0;
      bufp_q  <= '0;
      blen_q  <= '0;
      cnt_q   <= '0;
      cp_q    <= '0;
      last_q  <= '0;
      irq_q   <= 1'b0;
      ovr_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      nxt_q   <= nxt_d;
      bufp_q  <= bufp_d;
      blen_q  <= blen_d;
      cnt_q   <= cnt_d;
      cp_q    <= cp_d;
      last_q  <= last_d;
      irq_q   <= irq_d;
      ovr_q   <= ovr_d;
    end
  end

  assign s_ready     = (state_q == ST_RECV) || (state_q == ST_DROP);
  assign active      = (state_q != ST_IDLE);
  assign cp_rdata    = cp_q;
  assign irq_raw     = irq_q;
  assign overrun_cnt = ovr_q;

  AST_EOQ_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dhw_we && dhw_wdata[FLG_EOQ]) |=> !active);  // R6
  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    dhw_we |=> irq_raw);  // R9
  AST_TEARDOWN_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    teardown |=> (cp_rdata == TEARDOWN_MARK && !active));  // R10
  AST_ZERO_HEAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && head_we && head_wdata == '0 && !teardown) |=> !active);  // R2
  AST_OVR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_cnt != $past(overrun_cnt)) |-> (overrun_cnt == $past(overrun_cnt) + 1'b1));  // R8
endmodule

// File: rtl/rxdma_chan.sv
`timescale 1ns/1ps
module rxdma_chan #(
  parameter int DESC_WORDS = 64,
  parameter int BUF_BYTES  = 256,
  parameter int OVW        = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dsc_wr_en,
  input  logic [$clog2(DESC_WORDS)-1:0] dsc_wr_addr,
  input  logic [31:0]                   dsc_wr_data,
  input  logic [$clog2(DESC_WORDS)-1:0] dsc_rd_addr,
  output logic [31:0]                   dsc_rd_data,
  input  logic [$clog2(BUF_BYTES)-1:0]  buf_rd_addr,
  output logic [7:0]                    buf_rd_data,
  input  logic                          head_wr_en,
  input  logic [31:0]                   head_wr_data,
  input  logic                          cpl_wr_en,
  input  logic [31:0]                   cpl_wr_data,
  output logic [31:0]                   cpl_rd_data,
  input  logic                          teardown_req,
  input  logic [15:0]                   max_len,
  input  logic                          in_valid,
  input  logic [7:0]                    in_data,
  input  logic                          in_last,
  output logic                          in_ready,
  output logic                          chan_active,
  output logic                          irq_raw,
  output logic [OVW-1:0]                overrun_cnt
);
  localparam int DAW = $clog2(DESC_WORDS);
  localparam int BAW = $clog2(BUF_BYTES);

  logic [DAW-3:0]   desc_idx;
  logic [3:0][31:0] desc_words;
  logic             dhw_we;
  logic [1:0]       dhw_sel;
  logic [31:0]      dhw_wdata;
  logic             bw_we;
  logic [BAW-1:0]   bw_addr;
  logic [7:0]       bw_data;

  rxd_desc_ram #(.DESC_WORDS(DESC_WORDS)) u_desc (
    .clk      (clk),
    .sw_we    (dsc_wr_en),
    .sw_waddr (dsc_wr_addr),
    .sw_wdata (dsc_wr_data),
    .sw_raddr (dsc_rd_addr),
    .sw_rdata (dsc_rd_data),
    .hw_idx   (desc_idx),
    .hw_words (desc_words),
    .hw_we    (dhw_we),
    .hw_sel   (dhw_sel),
    .hw_wdata (dhw_wdata)
  );

  rxd_buf_ram #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk   (clk),
    .we    (bw_we),
    .waddr (bw_addr),
    .wdata (bw_data),
    .raddr (buf_rd_addr),
    .rdata (buf_rd_data)
  );

  rxd_ctrl #(.DAW(DAW), .BAW(BAW), .OVW(OVW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .head_we     (head_wr_en),
    .head_wdata  (head_wr_data),
    .cp_we       (cpl_wr_en),
    .cp_wdata    (cpl_wr_data),
    .cp_rdata    (cpl_rd_data),
    .teardown    (teardown_req),
    .max_len     (max_len),
    .s_valid     (in_valid),
    .s_data      (in_data),
    .s_last      (in_last),
    .s_ready     (in_ready),
    .desc_idx    (desc_idx),
    .desc_words  (desc_words),
    .dhw_we      (dhw_we),
    .dhw_sel     (dhw_sel),
    .dhw_wdata   (dhw_wdata),
    .bw_we       (bw_we),
    .bw_addr     (bw_addr),
    .bw_data     (bw_data),
    .active      (chan_active),
    .irq_raw     (irq_raw),
    .overrun_cnt (overrun_cnt)
  );
endmodule

// File: tb/rxdma_chan_test.sv
`timescale 1ns/1ps
module rxdma_chan_test;
  localparam logic [31:0] SOP = 32'h8000_0000;
  localparam logic [31:0] EOP = 32'h4000_0000;
  localparam logic [31:0] OWN = 32'h2000_0000;
  localparam logic [31:0] EOQ = 32'h1000_0000;
  localparam logic [31:0] ERR = 32'h0400_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dsc_wr_en = 1'b0;
  logic [5:0] dsc_wr_addr = '0;
  logic [31:0] dsc_wr_data = '0;
  logic [5:0] dsc_rd_addr = '0;
  logic [31:0] dsc_rd_data;
  logic [7:0] buf_rd_addr = '0;
  logic [7:0] buf_rd_data;
  logic head_wr_en = 1'b0;
  logic [31:0] head_wr_data = '0;
  logic cpl_wr_en = 1'b0;
  logic [31:0] cpl_wr_data = '0;
  logic [31:0] cpl_rd_data;
  logic teardown_req = 1'b0;
  logic [15:0] max_len = 16'd60;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_last = 1'b0;
  logic in_ready, chan_active, irq_raw;
  logic [7:0] overrun_cnt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] flags;
    logic [7:0]  bufp;
    int          stored;
    logic [7:0]  seed;
    string       req;
  } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  rxdma_chan uut (
    .clk(clk), .rst_n(rst_n),
    .dsc_wr_en(dsc_wr_en), .dsc_wr_addr(dsc_wr_addr), .dsc_wr_data(dsc_wr_data),
    .dsc_rd_addr(dsc_rd_addr), .dsc_rd_data(dsc_rd_data),
    .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
    .head_wr_en(head_wr_en), .head_wr_data(head_wr_data),
    .cpl_wr_en(cpl_wr_en), .cpl_wr_data(cpl_wr_data), .cpl_rd_data(cpl_rd_data),
    .teardown_req(teardown_req), .max_len(max_len),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .chan_active(chan_active), .irq_raw(irq_raw), .overrun_cnt(overrun_cnt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wr_word(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    dsc_wr_en = 1'b1; dsc_wr_addr = a; dsc_wr_data = d;
    @(negedge clk);
    dsc_wr_en = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt,
                          input logic [31:0] bp, input logic [15:0] len,
                          input logic [31:0] flg);
    wr_word(a[7:2] + 6'd0, nxt);
    wr_word(a[7:2] + 6'd1, bp);
    wr_word(a[7:2] + 6'd2, {16'd0, len});
    wr_word(a[7:2] + 6'd3, flg);
  endtask

  task automatic write_head(input logic [31:0] v);
    @(negedge clk);
    head_wr_en = 1'b1; head_wr_data = v;
    @(negedge clk);
    head_wr_en = 1'b0;
  endtask

  task automatic send_frame(input int len, input logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = seed + 8'(i);
      in_last  = (i == len - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  // driver side: record what the monitor should see, then send the frame
  task automatic expect_frame(input logic [31:0] a, input logic [31:0] flg,
                              input logic [7:0] bp, input int len, input int blen,
                              input logic [7:0] seed, input string req);
    item_t it;
    it.addr = a; it.flags = flg; it.bufp = bp;
    it.stored = (len < blen) ? len : blen;
    it.seed = seed; it.req = req;
    exp_q.push_back(it);
    send_frame(len, seed);
  endtask

  // monitor: each completion is compared against the scoreboard head
  initial begin
    forever begin
      item_t it;
      logic ok;
      @(posedge irq_raw);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        check("R9 unexpected completion", 32'd1, 32'd0);
      end else begin
        it = exp_q.pop_front();
        dsc_rd_addr = it.addr[7:2] + 6'd3;
        #1;
        check({it.req, " flags"}, dsc_rd_data, it.flags);
        ok = 1'b1;
        for (int i = 0; i < it.stored; i++) begin
          buf_rd_addr = it.bufp + 8'(i);
          #0.1;
          if (buf_rd_data !== it.seed + 8'(i)) ok = 1'b0;
        end
        check("R4 buffer bytes", {31'd0, ok}, 32'd1);
        @(negedge clk);
        cpl_wr_en = 1'b1; cpl_wr_data = 32'h4;
        @(negedge clk);
        cpl_wr_en = 1'b0;
        check("R9 irq kept after other ack", {31'd0, irq_raw}, 32'd1);
        cpl_wr_en = 1'b1; cpl_wr_data = it.addr;
        @(negedge clk);
        cpl_wr_en = 1'b0;
        check("R9 irq cleared by ack", {31'd0, irq_raw}, 32'd0);
        check("R10 completion readback", cpl_rd_data, it.addr);
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 active", {31'd0, chan_active}, 32'd0);
    check("R1 ready", {31'd0, in_ready}, 32'd0);
    check("R1 irq", {31'd0, irq_raw}, 32'd0);
    check("R1 overrun", {24'd0, overrun_cnt}, 32'd0);
    check("R1 cp", cpl_rd_data, 32'd0);
    rst_n = 1'b1;

    // chain of three, R3 layout
    put_desc(32'h10, 32'h20, 32'h00, 16'd64, OWN);
    put_desc(32'h20, 32'h30, 32'h40, 16'd64, OWN);
    put_desc(32'h30, 32'h00, 32'h80, 16'd64, OWN);
    write_head(32'h0);
    check("R2 zero head stays idle", {31'd0, chan_active}, 32'd0);
    write_head(32'h10);
    check("R2 head starts channel", {31'd0, chan_active}, 32'd1);
    expect_frame(32'h10, SOP | EOP | 32'd10, 8'h00, 10, 64, 8'h01, "R5 frame1");
    expect_frame(32'h20, SOP | EOP | 32'd1, 8'h40, 1, 64, 8'h30, "R5 single byte");
    expect_frame(32'h30, SOP | EOP | EOQ | ERR | 32'd70, 8'h80, 70, 64, 8'h50, "R7 R6 long frame");
    check("R6 stopped at end of queue", {31'd0, chan_active}, 32'd0);
    check("R6 not ready when stopped", {31'd0, in_ready}, 32'd0);

    // descriptor not yet owned: frame dropped
    put_desc(32'h40, 32'h00, 32'hC0, 16'd32, 32'd0);
    write_head(32'h40);
    send_frame(5, 8'hA0);
    check("R8 overrun count", {24'd0, overrun_cnt}, 32'd1);
    check("R8 still active", {31'd0, chan_active}, 32'd1);
    write_head(32'h30);  // R2: ignored while active
    wr_word(6'h13, OWN);
    expect_frame(32'h40, SOP | EOP | EOQ | 32'd8, 8'hC0, 8, 32, 8'h90, "R8 R2 resumed desc");
    check("R8 overrun unchanged", {24'd0, overrun_cnt}, 32'd1);

    // restart after end of queue
    put_desc(32'h10, 32'h00, 32'h00, 16'd64, OWN);
    write_head(32'h10);
    expect_frame(32'h10, SOP | EOP | EOQ | 32'd4, 8'h00, 4, 64, 8'h20, "R6 restart");

    // teardown
    put_desc(32'h20, 32'h00, 32'h40, 16'd64, 32'd0);
    write_head(32'h20);
    check("R10 active before teardown", {31'd0, chan_active}, 32'd1);
    @(negedge clk); teardown_req = 1'b1;
    @(negedge clk); teardown_req = 1'b0;
    check("R10 teardown stops", {31'd0, chan_active}, 32'd0);
    check("R10 teardown marker", cpl_rd_data, 32'hFFFF_FFFC);
    @(negedge clk); cpl_wr_en = 1'b1; cpl_wr_data = 32'hFFFF_FFFC;
    @(negedge clk); cpl_wr_en = 1'b0;
    write_head(32'h0);
    check("R10 marker written back", cpl_rd_data, 32'hFFFF_FFFC);
    check("R2 idle after clear", {31'd0, chan_active}, 32'd0);
    check("R9 all completions seen", exp_q.size(), 32'd0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule